// File: doc/BRIEF.md
# Monte Carlo Lattice Conduction Estimator

This block measures, by repeated random experiment, how likely a square or rectangular switch lattice is to conduct between its top edge and its bottom edge. In every trial each site of a ROWS x COLS lattice is closed on its own with a programmable probability, drawn from an internal pseudo-random generator. A flood-fill then spreads from the closed sites of the top row through closed orthogonal neighbours, and the trial is a hit when any bottom-row site is reached. After the programmed number of trials the block holds the hit count, whose ratio to the trial count approximates the global conduction probability.

The result can also be read as a logic level. Two programmable fractions set a one-threshold and a zero-threshold. A hit ratio above the first reads as logic one, a ratio below the second reads as logic zero, and anything else is undecided. Sweeping the closure probability and the lattice size shows how the connection probability sharpens into a step as the lattice grows.

Top module: `perc_mc_estimator`

## Requirements
- R1: A start pulse is accepted only while busy is low. It captures p1_frac, seed, trial_count and both thresholds, clears hits and raises busy in the next cycle when trial_count is nonzero. A start pulse while busy is high has no effect on the run in progress.
- R2: A site is closed when its 8-bit sample is strictly less than p1_frac. So p1_frac = 0 never closes a site and gives zero hits.
- R3: Samples come from a 32-bit Galois LFSR that shifts right and XORs 32'h80200003 when the bit shifted out is 1. It is loaded from seed at start, or with 32'h00000001 when seed is 0. Each site advances it 8 steps and uses bits [7:0] of the new state. Sites are visited row 0 first and column 0 first, and the state carries over from trial to trial.
- R4: Conduction spreads only between orthogonal neighbours that are both closed, starting from the closed sites of row 0. A trial is a hit when any site of row ROWS-1 is reached. Diagonal contact does not conduct.
- R5: When done rises, hits equals the number of hit trials and never exceeds trial_count. Within a run hits grows by at most one per cycle. done and hits then hold until the next accepted start.
- R6: A trial_count of 0 raises done one cycle after start, with hits = 0.
- R7: verdict is 2'b01 when hits*256 > one_thr*trial_count. Otherwise it is 2'b00 when hits*256 < zero_thr*trial_count, and otherwise 2'b10. It reads 2'b10 whenever done is low.
- R8: ROWS and COLS are parameters. A 6x6 lattice gives a higher hit ratio than a 1x1 lattice at p1_frac = 200, and a lower one at p1_frac = 50.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (pulse) |
| p1_frac | input | 8 | Site closure probability, value/256 |
| seed | input | 32 | LFSR seed, 0 replaced by 1 |
| trial_count | input | 16 | Number of trials |
| one_thr | input | 8 | One-threshold fraction, value/256 |
| zero_thr | input | 8 | Zero-threshold fraction, value/256 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Results valid, held until next start |
| hits | output | 16 | Number of conducting trials |
| verdict | output | 2 | 01 one, 00 zero, 10 undecided |

## Verification
A bench model draws the same LFSR sample stream and floods each lattice, so the hit count of a 6x6 and a 1x1 instance is matched exactly over random seeds, probabilities and trial counts. This separates errors in sample order, comparison sense and neighbour rules: a diagonal link or an off-by-one compare moves the count. Directed runs cover p1_frac 0 and 255, a zero trial count, seed 0 against seed 1, a start during a run, and a high and a low p1_frac that show the larger lattice switching more sharply. Thresholds are drawn so that the verdict lands on one, zero and undecided.

// File: rtl/perc_pkg.sv
// Shared constants, types and the LFSR step for the lattice estimator.
package perc_pkg;
    localparam int          SAMPLE_W      = 8;
    localparam int          LFSR_W        = 32;
    localparam logic [31:0] LFSR_TAPS     = 32'h80200003;
    localparam logic [31:0] LFSR_FALLBACK = 32'h00000001;

    typedef enum logic [1:0] {
        VERDICT_ZERO = 2'b00,
        VERDICT_ONE  = 2'b01,
        VERDICT_OPEN = 2'b10
    } verdict_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_FILL,
        PH_FIN
    } phase_e;

    // One right-shift Galois step of the maximal-length generator.
    function automatic logic [31:0] lfsr_next(input logic [31:0] s);
        return {1'b0, s[31:1]} ^ (s[0] ? LFSR_TAPS : 32'h0);
    endfunction
endpackage

// File: rtl/perc_site_sampler.sv
// Draws one lattice row of closed/open sites per cycle.
// Assumes: load and advance are never high together; the state is
// advanced SW steps per site, COLS sites per row, unrolled combinationally.
module perc_site_sampler #(
    parameter int COLS = 6,
    parameter int SW   = perc_pkg::SAMPLE_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [31:0]     seed,
    input  logic [SW-1:0]   p1,
    input  logic            advance,
    output logic [COLS-1:0] row_closed
);
    localparam int STEPS = COLS * SW;

    logic [31:0]   state_q;
    logic [SW-1:0] p1_q;
    logic [31:0]   chain [STEPS+1];

    assign chain[0] = state_q;

    // Unrolled generator steps covering one full row.
    for (genvar k = 0; k < STEPS; k++) begin : g_step
        assign chain[k+1] = perc_pkg::lfsr_next(chain[k]);
    end

    // Per-site closure decision: sample strictly below p1.
    for (genvar c = 0; c < COLS; c++) begin : g_site
        assign row_closed[c] = (chain[(c+1)*SW][SW-1:0] < p1_q);
    end

    // Generator state and latched probability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= perc_pkg::LFSR_FALLBACK;
            p1_q    <= '0;
        end else if (load) begin
            state_q <= (seed == 32'h0) ? perc_pkg::LFSR_FALLBACK : seed;
            p1_q    <= p1;
        end else if (advance) begin
            state_q <= chain[STEPS];
        end
    end
endmodule

// File: rtl/perc_flood_fill.sv
// Holds the sampled lattice and grows the set of sites reachable from the
// top row, one neighbour hop per cycle, until the set stops changing.
// Assumes: fill_clr is held during sampling so the fill starts empty.
module perc_flood_fill #(
    parameter int ROWS = 6,
    parameter int COLS = 6,
    localparam int RW  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            row_we,
    input  logic [RW-1:0]   row_idx,
    input  logic [COLS-1:0] row_bits,
    input  logic            fill_clr,
    input  logic            fill_en,
    output logic            stable,
    output logic            hit
);
    logic [ROWS-1:0][COLS-1:0] closed_q;
    logic [ROWS-1:0][COLS-1:0] reach_q;
    logic [ROWS-1:0][COLS-1:0] reach_d;

    // Next reached set: closed and touching the top plate or a reached neighbour.
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic from_up, from_dn, from_lt, from_rt;
            if (r == 0) begin : g_top
                assign from_up = 1'b1;
            end else begin : g_up
                assign from_up = reach_q[r-1][c];
            end
            if (r == ROWS - 1) begin : g_bot
                assign from_dn = 1'b0;
            end else begin : g_dn
                assign from_dn = reach_q[r+1][c];
            end
            if (c == 0) begin : g_lft
                assign from_lt = 1'b0;
            end else begin : g_lt
                assign from_lt = reach_q[r][c-1];
            end
            if (c == COLS - 1) begin : g_rgt
                assign from_rt = 1'b0;
            end else begin : g_rt
                assign from_rt = reach_q[r][c+1];
            end
            assign reach_d[r][c] = closed_q[r][c] & (from_up | from_dn | from_lt | from_rt);
        end
    end

    assign stable = (reach_d == reach_q);
    assign hit    = |reach_q[ROWS-1];

    // Lattice storage: one row written per sampling cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)      closed_q <= '0;
        else if (row_we) closed_q[row_idx] <= row_bits;
    end

    // Reached set: cleared while sampling, relaxed while filling.
    always_ff @(posedge clk) begin
        if (!rst_n || fill_clr) reach_q <= '0;
        else if (fill_en)       reach_q <= reach_d;
    end
endmodule

// File: rtl/perc_trial_ctrl.sv
// Sequences trials (sample rows, then fill), counts hits and grades the
// hit ratio against the two thresholds.
// Assumes: fill_stable/fill_hit come from a fill cleared during sampling.
module perc_trial_ctrl #(
    parameter int ROWS   = 6,
    parameter int CNT_W  = 16,
    parameter int FRAC_W = perc_pkg::SAMPLE_W,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  trial_count,
    input  logic [FRAC_W-1:0] one_thr,
    input  logic [FRAC_W-1:0] zero_thr,
    input  logic              fill_stable,
    input  logic              fill_hit,
    output logic              load,
    output logic              row_we,
    output logic [RW-1:0]     row_idx,
    output logic              fill_clr,
    output logic              fill_en,
    output logic              busy,
    output logic              done,
    output logic [CNT_W-1:0]  hits,
    output perc_pkg::verdict_e verdict
);
    import perc_pkg::*;

    localparam int PW = CNT_W + FRAC_W;

    phase_e            phase_q;
    logic [RW-1:0]     row_q;
    logic [CNT_W-1:0]  trials_q;
    logic [CNT_W-1:0]  ran_q;
    logic [CNT_W-1:0]  hits_q;
    logic [FRAC_W-1:0] one_q;
    logic [FRAC_W-1:0] zero_q;
    logic [PW-1:0]     scaled_hits;
    logic [PW-1:0]     one_lim;
    logic [PW-1:0]     zero_lim;

    assign busy     = (phase_q == PH_SAMPLE) || (phase_q == PH_FILL);
    assign done     = (phase_q == PH_FIN);
    assign load     = start && !busy;
    assign row_we   = (phase_q == PH_SAMPLE);
    assign row_idx  = row_q;
    assign fill_clr = (phase_q == PH_SAMPLE);
    assign fill_en  = (phase_q == PH_FILL);
    assign hits     = hits_q;

    // Threshold comparison in the count domain avoids any division.
    assign scaled_hits = {hits_q, {FRAC_W{1'b0}}};
    assign one_lim     = PW'(trials_q) * PW'(one_q);
    assign zero_lim    = PW'(trials_q) * PW'(zero_q);

    // Verdict: one has priority, ties are undecided, undecided until done.
    always_comb begin
        if (!done)                        verdict = VERDICT_OPEN;
        else if (scaled_hits > one_lim)   verdict = VERDICT_ONE;
        else if (scaled_hits < zero_lim)  verdict = VERDICT_ZERO;
        else                              verdict = VERDICT_OPEN;
    end

    // Run sequencer, trial counter and saturating hit counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q  <= PH_IDLE;
            row_q    <= '0;
            trials_q <= '0;
            ran_q    <= '0;
            hits_q   <= '0;
            one_q    <= '0;
            zero_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE, PH_FIN: begin
                    if (load) begin
                        trials_q <= trial_count;
                        one_q    <= one_thr;
                        zero_q   <= zero_thr;
                        hits_q   <= '0;
                        ran_q    <= '0;
                        row_q    <= '0;
                        phase_q  <= (trial_count == '0) ? PH_FIN : PH_SAMPLE;
                    end
                end
                PH_SAMPLE: begin
                    if (row_q == RW'(ROWS - 1)) begin
                        row_q   <= '0;
                        phase_q <= PH_FILL;
                    end else begin
                        row_q <= row_q + 1'b1;
                    end
                end
                PH_FILL: begin
                    if (fill_stable) begin
                        if (fill_hit && (hits_q != trials_q)) hits_q <= hits_q + 1'b1;
                        ran_q   <= ran_q + 1'b1;
                        phase_q <= (ran_q + 1'b1 == trials_q) ? PH_FIN : PH_SAMPLE;
                    end
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/perc_mc_estimator.sv
// Top: Monte Carlo estimator of top-to-bottom lattice conduction probability.
// Assumes: inputs are sampled only on the cycle start is accepted.
module perc_mc_estimator #(
    parameter int ROWS  = 6,
    parameter int COLS  = 6,
    parameter int CNT_W = 16,
    localparam int FW   = perc_pkg::SAMPLE_W,
    localparam int RW   = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [FW-1:0]    p1_frac,
    input  logic [31:0]      seed,
    input  logic [CNT_W-1:0] trial_count,
    input  logic [FW-1:0]    one_thr,
    input  logic [FW-1:0]    zero_thr,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] hits,
    output logic [1:0]       verdict
);
    logic            load, row_we, fill_clr, fill_en, fill_stable, fill_hit;
    logic [RW-1:0]   row_idx;
    logic [COLS-1:0] row_closed;
    perc_pkg::verdict_e verdict_w;

    assign verdict = verdict_w;

    perc_site_sampler #(.COLS(COLS), .SW(FW)) u_samp (
        .clk(clk), .rst_n(rst_n), .load(load), .seed(seed), .p1(p1_frac),
        .advance(row_we), .row_closed(row_closed)
    );

    perc_flood_fill #(.ROWS(ROWS), .COLS(COLS)) u_fill (
        .clk(clk), .rst_n(rst_n), .row_we(row_we), .row_idx(row_idx),
        .row_bits(row_closed), .fill_clr(fill_clr), .fill_en(fill_en),
        .stable(fill_stable), .hit(fill_hit)
    );

    perc_trial_ctrl #(.ROWS(ROWS), .CNT_W(CNT_W), .FRAC_W(FW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .trial_count(trial_count),
        .one_thr(one_thr), .zero_thr(zero_thr), .fill_stable(fill_stable),
        .fill_hit(fill_hit), .load(load), .row_we(row_we), .row_idx(row_idx),
        .fill_clr(fill_clr), .fill_en(fill_en), .busy(busy), .done(done),
        .hits(hits), .verdict(verdict_w)
    );
endmodule

// File: rtl/perc_mc_estimator_chk.sv
// Property checker for the estimator, attached by bind.
module perc_mc_estimator_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] trial_count,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] hits,
    input logic [1:0]       verdict,
    input logic [CNT_W-1:0] trials_q,
    input logic [7:0]       p1_q
);
    // R1: accepted start with work to do raises busy next cycle
    a_r1_busy_on_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && trial_count != '0) |=> busy);
    // R1: running and finished are exclusive
    a_r1_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    // R2: zero probability never yields a hit
    a_r2_zero_p1_no_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (done && p1_q == 8'd0) |-> hits == '0);
    // R5: hit count bounded by trial count
    a_r5_hits_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> hits <= trials_q);
    // R5: hit count grows by at most one per cycle while running
    a_r5_hits_step: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (hits == $past(hits) || hits == $past(hits) + 1'b1));
    // R5: results hold until a new start
    a_r5_results_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(hits)));
    // R6: zero trial count finishes next cycle with no hits
    a_r6_empty_run: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && trial_count == '0) |=> (done && hits == '0));
    // R7: verdict undecided while not done
    a_r7_open_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> verdict == 2'b10);
endmodule

bind perc_mc_estimator perc_mc_estimator_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .trial_count(trial_count),
    .busy(busy), .done(done), .hits(hits), .verdict(verdict),
    .trials_q(u_ctrl.trials_q), .p1_q(u_samp.p1_q)
);

// File: tb/perc_mc_estimator_tb.sv
module perc_mc_estimator_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  p1_frac = '0;
    logic [31:0] seed = '0;
    logic [15:0] trial_count = '0;
    logic [7:0]  one_thr = '0;
    logic [7:0]  zero_thr = '0;

    logic        busy6, done6, busy1, done1;
    logic [15:0] hits6, hits1;
    logic [1:0]  vd6, vd1;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit timed_out = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    perc_mc_estimator #(.ROWS(6), .COLS(6)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .p1_frac(p1_frac), .seed(seed),
        .trial_count(trial_count), .one_thr(one_thr), .zero_thr(zero_thr),
        .busy(busy6), .done(done6), .hits(hits6), .verdict(vd6));

    perc_mc_estimator #(.ROWS(1), .COLS(1)) u_small (
        .clk(clk), .rst_n(rst_n), .start(start), .p1_frac(p1_frac), .seed(seed),
        .trial_count(trial_count), .one_thr(one_thr), .zero_thr(zero_thr),
        .busy(busy1), .done(done1), .hits(hits1), .verdict(vd1));

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == WATCHDOG) timed_out <= 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_step(input logic [31:0] s);
        return (s >> 1) ^ (s[0] ? 32'h80200003 : 32'h0);
    endfunction

    // Reference per R2/R3/R4: same sample stream, orthogonal flood from row 0.
    function automatic int ref_hits(input logic [31:0] sd, input logic [7:0] p,
                                    input int n, input int rows, input int cols);
        logic [31:0] s;
        bit cl [8][8];
        bit rc [8][8];
        bit nx [8][8];
        bit changed, hit;
        int h = 0;
        s = (sd == 32'h0) ? 32'h1 : sd;
        for (int t = 0; t < n; t++) begin
            for (int r = 0; r < rows; r++)
                for (int c = 0; c < cols; c++) begin
                    for (int k = 0; k < 8; k++) s = ref_step(s);
                    cl[r][c] = (s[7:0] < p);
                    rc[r][c] = 1'b0;
                end
            do begin
                changed = 1'b0;
                for (int r = 0; r < rows; r++)
                    for (int c = 0; c < cols; c++)
                        nx[r][c] = cl[r][c] && ((r == 0) ||
                            (r > 0 && rc[r-1][c]) || (r < rows-1 && rc[r+1][c]) ||
                            (c > 0 && rc[r][c-1]) || (c < cols-1 && rc[r][c+1]));
                for (int r = 0; r < rows; r++)
                    for (int c = 0; c < cols; c++) begin
                        if (nx[r][c] != rc[r][c]) changed = 1'b1;
                        rc[r][c] = nx[r][c];
                    end
            end while (changed);
            hit = 1'b0;
            for (int c = 0; c < cols; c++) if (rc[rows-1][c]) hit = 1'b1;
            if (hit) h++;
        end
        return h;
    endfunction

    // Expected verdict per R7.
    function automatic int ref_verdict(input int h, input int n, input int one, input int zero);
        if (h * 256 > one * n) return 1;
        if (h * 256 < zero * n) return 0;
        return 2;
    endfunction

    int last6, last1;

    // One run on both lattices; optional start pulse mid-run (R1).
    task automatic do_run(input logic [31:0] sd, input logic [7:0] p, input int n,
                          input logic [7:0] one, input logic [7:0] zero, input bit poke);
        int e6, e1;
        @(negedge clk);
        seed = sd; p1_frac = p; trial_count = 16'(n); one_thr = one; zero_thr = zero;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (n == 0) begin
            check(done6 && done1 && hits6 == 0 && hits1 == 0, "R6 empty run", int'(hits6), 0);
        end else begin
            check(busy6 && busy1, "R1 busy after start", int'(busy6), 1);
        end
        if (poke) begin
            repeat (3) @(negedge clk);
            p1_frac = 8'd255; trial_count = 16'd1; seed = 32'h1234; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!(done6 && done1) && !timed_out) @(negedge clk);
        e6 = ref_hits(sd, p, n, 6, 6);
        e1 = ref_hits(sd, p, n, 1, 1);
        check(int'(hits6) == e6, "R4 hits 6x6", int'(hits6), e6);
        check(int'(hits1) == e1, "R3 hits 1x1", int'(hits1), e1);
        check(int'(vd6) == ref_verdict(e6, n, one, zero), "R7 verdict 6x6", int'(vd6),
              ref_verdict(e6, n, one, zero));
        check(int'(vd1) == ref_verdict(e1, n, one, zero), "R7 verdict 1x1", int'(vd1),
              ref_verdict(e1, n, one, zero));
        repeat (3) @(negedge clk);
        check(done6 && int'(hits6) == e6, "R5 results held", int'(hits6), e6);
        last6 = int'(hits6);
        last1 = int'(hits1);
    endtask

    initial begin
        int s0, s1, hi6, hi1, lo6, lo1;
        void'($urandom(32'd20231));
        repeat (3) @(negedge clk);
        check(!busy6 && !done6 && hits6 == 0 && vd6 == 2'b10, "R7 reset state", int'(vd6), 2);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: p1 = 0 closes nothing
        do_run(32'hCAFE0001, 8'd0, 40, 8'd128, 8'd64, 1'b0);
        check(last6 == 0 && last1 == 0, "R2 p1 zero no hits", last6, 0);
        // Dense lattice
        do_run(32'h00ABCDEF, 8'd255, 60, 8'd200, 8'd50, 1'b0);
        // R6: empty run
        do_run(32'h5, 8'd100, 0, 8'd10, 8'd10, 1'b0);
        check(vd6 == 2'b10, "R7 empty run undecided", int'(vd6), 2);
        // R3: seed 0 behaves as seed 1
        do_run(32'h0, 8'd150, 50, 8'd128, 8'd128, 1'b0);
        s0 = last6;
        do_run(32'h1, 8'd150, 50, 8'd128, 8'd128, 1'b0);
        s1 = last6;
        check(s0 == s1, "R3 zero seed fallback", s0, s1);
        // R1: start during a run is ignored
        do_run(32'h7777AAAA, 8'd160, 30, 8'd100, 8'd30, 1'b1);
        // R8: larger lattice sharper
        do_run(32'h2468ACE1, 8'd200, 150, 8'd128, 8'd128, 1'b0);
        hi6 = last6; hi1 = last1;
        do_run(32'h13579BDF, 8'd50, 150, 8'd128, 8'd128, 1'b0);
        lo6 = last6; lo1 = last1;
        check(hi6 > hi1, "R8 sharper above", hi6, hi1);
        check(lo6 < lo1, "R8 sharper below", lo6, lo1);

        // Constrained random runs
        for (int i = 0; i < 10; i++) begin
            logic [31:0] rs;
            logic [7:0]  rp, ro, rz;
            int          rn;
            rs = $urandom();
            rp = 8'($urandom_range(60, 230));
            rn = $urandom_range(1, 120);
            ro = 8'($urandom_range(64, 250));
            rz = 8'($urandom_range(0, 128));
            do_run(rs, rp, rn, ro, rz, 1'b0);
        end

        if (timed_out) check(1'b0, "watchdog", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    // Watchdog exit path for a hung run.
    initial begin
        wait (timed_out);
        repeat (5) @(negedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=<%0d", cycles, WATCHDOG);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule